// File: doc/BRIEF.md
# 9-bit UART Transmitter with Collision Detect

This block serialises one byte, optionally followed by a ninth bit, as an asynchronous frame on a single output line. Software starts a frame simply by writing the transmit buffer; the frame is a low start bit, the eight data bits least significant first, the ninth bit when the 9-bit format is chosen, and a high stop bit. The line rests high between frames.

The bit clock is built from one of four external overflow pulse inputs, picked by a 2-bit source code. The picked pulse can be halved by a divide-by-two stage or passed through unchanged. Sixteen of these baud ticks make one bit period. Two sticky flags report to software. One is a completion flag that rises as the stop bit begins. The other is a collision flag that rises when the buffer is written while a frame is still on the line. A colliding write is dropped, and the frame in flight goes on unchanged.

Top module: `uart9_tx`

## Requirements
- R1: After reset the line is high, busy is 0, and the completion and collision flags are both 0.
- R2: A buffer write while busy is 0 starts a frame. From the next cycle busy is 1 and the line drives the low start bit.
- R3: Frame bit 0 is low (start). Bits 1 to 8 carry the data least significant bit first. With fmt9 = 1, bit 9 equals the bit9 input sampled at the accepted write, and bit 10 is the high stop bit. With fmt9 = 0, bit 9 is the high stop bit and bit9 has no effect.
- R4: Each bit lasts exactly 16 baud ticks. Busy falls, and the line stays high, on the 16th tick of the stop bit.
- R5: Source codes 0, 1, 2 and 3 on clk_src select ovf_pulse[0], [1], [2] and [3] as the baud source. Pulses on the unselected inputs have no effect.
- R6: With dbl_en = 1 every selected pulse is a baud tick. With dbl_en = 0 only every second selected pulse is a tick; the first selected pulse after reset is held back.
- R7: done_flag becomes 1 on the clock edge on which the stop bit begins. It stays 1 until a clr_done pulse. If set and clear fall in the same cycle, the set wins.
- R8: A buffer write while busy is 1 makes coll_flag 1 in the next cycle. It stays 1 until a clr_coll pulse. If set and clear fall in the same cycle, the set wins.
- R9: A colliding write is discarded. The remaining bits of the current frame are unchanged, and no frame follows once it ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Transmit buffer write strobe |
| wr_data | input | 8 | Byte written to the transmit buffer |
| fmt9 | input | 1 | Frame format: 1 = 9-bit, 0 = 8-bit |
| bit9 | input | 1 | Software-set ninth transmit bit |
| clk_src | input | 2 | Baud source code |
| dbl_en | input | 1 | 1 bypasses the divide-by-two stage |
| ovf_pulse | input | 4 | Timer overflow pulses, one per source |
| clr_done | input | 1 | Clears the completion flag |
| clr_coll | input | 1 | Clears the collision flag |
| txd | output | 1 | Serial line |
| done_flag | output | 1 | Sticky transmit-complete flag |
| coll_flag | output | 1 | Sticky transmit-collision flag |
| busy | output | 1 | A frame is on the line |

## Verification
Two pairs of events can land in one cycle: a flag set and its software clear. The bench provokes the first pair by raising clr_done in exactly the cycle whose clock edge starts the stop bit. It can do this because its own model of the divider knows one cycle ahead whether the next edge carries a baud tick. It provokes the second pair by sending clr_coll together with a buffer write in the middle of a frame. In both cases the flag must read 1 afterwards. The frame bits that follow the collision are also decoded and compared, so any effect of the dropped write shows up.

// File: rtl/uart9_tx_pkg.sv
package uart9_tx_pkg;

    localparam int DATA_W_DEF  = 8;
    localparam int OVS_DEF     = 16;
    localparam int NUM_SRC_DEF = 4;

    typedef enum logic {
        FMT_8BIT = 1'b0,
        FMT_9BIT = 1'b1
    } fmt_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    // Events raised by the shift engine toward the flag logic
    typedef struct packed {
        logic accept;
        logic collide;
        logic stop_enter;
    } tx_evt_t;

    // Value of the slot after the data bits: ninth bit or stop bit
    function automatic logic slot_after_data(input fmt_e fmt, input logic b9);
        return (fmt == FMT_9BIT) ? b9 : 1'b1;
    endfunction

endpackage

// File: rtl/uart9_src_sel.sv
module uart9_src_sel #(
    parameter int NUM_SRC = uart9_tx_pkg::NUM_SRC_DEF,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] ovf_pulse,
    input  logic [SEL_W-1:0]   src,
    output logic               pulse_o
);
    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = ovf_pulse[g] & (src == SEL_W'(g));
    end

    assign pulse_o = |hit;
endmodule

// File: rtl/uart9_half_div.sv
module uart9_half_div (
    input  logic clk,
    input  logic rst,
    input  logic pulse_i,
    input  logic bypass,
    output logic tick_o
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= 1'b0;
        else if (pulse_i)
            phase_q <= ~phase_q;
    end

    assign tick_o = pulse_i & (bypass | phase_q);
endmodule

// File: rtl/uart9_sticky.sv
module uart9_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/uart9_tx_core.sv
module uart9_tx_core
    import uart9_tx_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int OVS    = OVS_DEF,
    localparam int FRAME_MAX = DATA_W + 3,
    localparam int IDX_W     = $clog2(FRAME_MAX),
    localparam int OVS_W     = $clog2(OVS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  fmt_e              fmt,
    input  logic              b9,
    input  logic              tick,
    output logic              txd,
    output logic              busy,
    output tx_evt_t           evt
);
    localparam logic [IDX_W-1:0] LAST_8 = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0] LAST_9 = IDX_W'(DATA_W + 2);
    localparam logic [OVS_W-1:0] OVS_END = OVS_W'(OVS - 1);

    tx_state_e            state_q;
    logic [FRAME_MAX-1:0] shreg_q;
    logic [IDX_W-1:0]     idx_q;
    logic [IDX_W-1:0]     last_q;
    logic [OVS_W-1:0]     ovs_q;
    logic                 txd_q;

    logic [FRAME_MAX-1:0] frame_new;
    logic                 bit_end;

    always_comb begin
        frame_new             = '1;
        frame_new[0]          = 1'b0;
        frame_new[DATA_W:1]   = wr_data;
        frame_new[DATA_W+1]   = slot_after_data(fmt, b9);
    end

    assign bit_end = (state_q == TX_SEND) && tick && (ovs_q == OVS_END);

    always_comb begin
        evt.accept     = wr_stb && (state_q == TX_IDLE);
        evt.collide    = wr_stb && (state_q == TX_SEND);
        evt.stop_enter = bit_end && ((idx_q + IDX_W'(1)) == last_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            shreg_q <= '1;
            idx_q   <= '0;
            last_q  <= LAST_8;
            ovs_q   <= '0;
            txd_q   <= 1'b1;
        end else if (evt.accept) begin
            state_q <= TX_SEND;
            shreg_q <= frame_new;
            idx_q   <= '0;
            last_q  <= (fmt == FMT_9BIT) ? LAST_9 : LAST_8;
            ovs_q   <= '0;
            txd_q   <= frame_new[0];
        end else if (state_q == TX_SEND && tick) begin
            if (bit_end) begin
                ovs_q <= '0;
                if (idx_q == last_q) begin
                    state_q <= TX_IDLE;
                    txd_q   <= 1'b1;
                end else begin
                    idx_q   <= idx_q + IDX_W'(1);
                    shreg_q <= {1'b1, shreg_q[FRAME_MAX-1:1]};
                    txd_q   <= shreg_q[1];
                end
            end else begin
                ovs_q <= ovs_q + OVS_W'(1);
            end
        end
    end

    assign txd  = txd_q;
    assign busy = (state_q == TX_SEND);
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
    import uart9_tx_pkg::*;
#(
    parameter int DATA_W  = DATA_W_DEF,
    parameter int OVS     = OVS_DEF,
    parameter int NUM_SRC = NUM_SRC_DEF,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_stb,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               fmt9,
    input  logic               bit9,
    input  logic [SEL_W-1:0]   clk_src,
    input  logic               dbl_en,
    input  logic [NUM_SRC-1:0] ovf_pulse,
    input  logic               clr_done,
    input  logic               clr_coll,
    output logic               txd,
    output logic               done_flag,
    output logic               coll_flag,
    output logic               busy
);
    logic    src_pulse;
    logic    baud_tick;
    tx_evt_t evt;
    fmt_e    fmt;

    assign fmt = fmt9 ? FMT_9BIT : FMT_8BIT;

    uart9_src_sel #(.NUM_SRC(NUM_SRC)) u_sel (
        .ovf_pulse (ovf_pulse),
        .src       (clk_src),
        .pulse_o   (src_pulse)
    );

    uart9_half_div u_div (
        .clk     (clk),
        .rst     (rst),
        .pulse_i (src_pulse),
        .bypass  (dbl_en),
        .tick_o  (baud_tick)
    );

    uart9_tx_core #(.DATA_W(DATA_W), .OVS(OVS)) u_core (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .fmt     (fmt),
        .b9      (bit9),
        .tick    (baud_tick),
        .txd     (txd),
        .busy    (busy),
        .evt     (evt)
    );

    uart9_sticky u_done (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt.stop_enter),
        .clr_i  (clr_done),
        .flag_o (done_flag)
    );

    uart9_sticky u_coll (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt.collide),
        .clr_i  (clr_coll),
        .flag_o (coll_flag)
    );
endmodule

// File: rtl/uart9_tx_chk.sv
module uart9_tx_chk (
    input logic clk,
    input logic rst,
    input logic wr_stb,
    input logic clr_done,
    input logic clr_coll,
    input logic baud_tick,
    input logic txd,
    input logic busy,
    input logic done_flag,
    input logic coll_flag
);
    // R1: an idle line rests high
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    // R2: an accepted write drives the start bit next cycle
    assert_start_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !busy) |=> (busy && !txd));

    // R4: without a baud tick the line and busy hold
    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !baud_tick) |=> ($stable(txd) && busy));

    // R7: completion rises only while the high stop bit is on the line
    assert_done_at_stop_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> (busy && txd));

    // R7: completion flag holds until cleared
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (done_flag && !clr_done) |=> done_flag);

    // R8: a write during a frame sets the collision flag, even with a clear
    assert_coll_set_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && busy) |=> coll_flag);

    // R8: collision flag holds until cleared
    assert_coll_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (coll_flag && !clr_coll) |=> coll_flag);
endmodule

bind uart9_tx uart9_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .clr_done  (clr_done),
    .clr_coll  (clr_coll),
    .baud_tick (baud_tick),
    .txd       (txd),
    .busy      (busy),
    .done_flag (done_flag),
    .coll_flag (coll_flag)
);

// File: tb/uart9_tx_tb.sv
module uart9_tx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fmt9 = 1'b0;
    logic       bit9 = 1'b0;
    logic [1:0] clk_src = 2'd0;
    logic       dbl_en = 1'b1;
    logic [3:0] ovf_pulse = 4'h0;
    logic       clr_done = 1'b0;
    logic       clr_coll = 1'b0;
    logic       txd, done_flag, coll_flag, busy;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cycles   = 0;
    logic half_m  = 1'b0;   // bench model of the divide-by-two phase

    always #5 clk = ~clk;

    uart9_tx u_dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .fmt9(fmt9), .bit9(bit9), .clk_src(clk_src), .dbl_en(dbl_en),
        .ovf_pulse(ovf_pulse), .clr_done(clr_done), .clr_coll(clr_coll),
        .txd(txd), .done_flag(done_flag), .coll_flag(coll_flag), .busy(busy)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(input int j, input logic [7:0] d,
                                     input logic f9, input logic b9);
        if (j == 0)      return 1'b0;
        else if (j <= 8) return d[j-1];
        else if (j == 9) return f9 ? b9 : 1'b1;
        else             return 1'b1;
    endfunction

    // one cycle: drive ovf at negedge, update model at posedge, return at negedge
    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            ovf_pulse = 4'($urandom());
            @(posedge clk);
            if (ovf_pulse[clk_src]) half_m = ~half_m;
            @(negedge clk);
        end
    endtask

    task automatic run_frame(input logic [7:0] d, input logic f9, input logic b9,
                             input logic [1:0] src, input logic d_en,
                             input int coll_at, input logic clr_at_stop,
                             input logic clr_with_coll);
        int   n = f9 ? 11 : 10;
        int   count = 0;
        logic pred;
        logic coll_pending = 1'b0;
        logic coll_issued  = 1'b0;
        // clear both flags first
        ovf_pulse = 4'h0;
        clr_done = 1'b1; clr_coll = 1'b1;
        @(negedge clk);
        clr_done = 1'b0; clr_coll = 1'b0;
        @(negedge clk);
        chk(done_flag == 1'b0, "R7", "done after clear", done_flag, 0);
        chk(coll_flag == 1'b0, "R8", "coll after clear", coll_flag, 0);
        clk_src = src; dbl_en = d_en; fmt9 = f9; bit9 = b9; wr_data = d;
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        bit9 = ~b9;   // must not alter the captured ninth bit
        chk(busy == 1'b1 && txd == 1'b0, "R2", "start bit busy/txd",
            {busy, txd}, 2);
        forever begin
            ovf_pulse = 4'($urandom());
            pred = ovf_pulse[src] & (d_en | half_m);
            wr_stb = 1'b0; clr_done = 1'b0; clr_coll = 1'b0;
            if (coll_at > 0 && count == coll_at && !coll_issued) begin
                wr_stb = 1'b1; wr_data = ~d; clr_coll = clr_with_coll;
                coll_pending = 1'b1; coll_issued = 1'b1;
            end
            if (clr_at_stop && pred && count + 1 == 16 * (n - 1))
                clr_done = 1'b1;
            @(posedge clk);
            if (ovf_pulse[src]) half_m = ~half_m;
            if (pred) count++;
            @(negedge clk);
            wr_stb = 1'b0; clr_done = 1'b0; clr_coll = 1'b0;
            if (coll_pending) begin
                chk(coll_flag == 1'b1, "R8", "collision flag", coll_flag, 1);
                coll_pending = 1'b0;
            end
            if (pred) begin
                if (count % 16 == 8 && count / 16 < n)
                    chk(txd == exp_bit(count / 16, d, f9, b9), "R3",
                        $sformatf("frame bit %0d", count / 16), txd,
                        exp_bit(count / 16, d, f9, b9));
                if (count == 16 * (n - 1) - 1)
                    chk(done_flag == 1'b0, "R7", "done before stop", done_flag, 0);
                if (count == 16 * (n - 1))
                    chk(done_flag == 1'b1 && txd == 1'b1, "R7", "done at stop start",
                        {done_flag, txd}, 3);
                if (count % 16 == 0 && count < 16 * n)
                    chk(busy == 1'b1, "R4", "busy within frame", busy, 1);
                if (count == 16 * n) begin
                    chk(busy == 1'b0 && txd == 1'b1, "R4", "end of stop bit",
                        {busy, txd}, 1);
                    break;
                end
            end
        end
        idle_cycles(24);
        chk(busy == 1'b0 && txd == 1'b1, "R9", "no frame after end",
            {busy, txd}, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1 && busy == 1'b0, "R1", "reset line/busy", {txd, busy}, 2);
        chk(done_flag == 1'b0 && coll_flag == 1'b0, "R1", "reset flags",
            {done_flag, coll_flag}, 0);
        // R3 R5: 8-bit, ninth input ignored, source 0, no divide
        run_frame(8'hA5, 1'b0, 1'b1, 2'd0, 1'b1, 0, 1'b0, 1'b0);
        // R3 R6: 9-bit, ninth = 1, source 3, divided
        run_frame(8'h3C, 1'b1, 1'b1, 2'd3, 1'b0, 0, 1'b0, 1'b0);
        // R8 R9: collision with concurrent clear, source 1
        run_frame(8'h81, 1'b1, 1'b0, 2'd1, 1'b0, 40, 1'b0, 1'b1);
        // R7: clear in the stop-entry cycle, source 2
        run_frame(8'h5A, 1'b0, 1'b0, 2'd2, 1'b1, 0, 1'b1, 1'b0);
        // random frames
        for (int k = 0; k < 18; k++) begin
            logic       f9r = 1'($urandom());
            int         nr  = f9r ? 11 : 10;
            int         cat = ($urandom() % 2 == 0) ? 0
                              : 1 + int'($urandom() % (16 * nr - 20));
            run_frame(8'($urandom()), f9r, 1'($urandom()), 2'($urandom()),
                      1'($urandom()), cat, 1'($urandom()), 1'($urandom()));
        end
        summary();
        $finish;
    end
endmodule